// File: doc/BRIEF.md
# Serial ADC Interface Sequencer

This block is the device-side digital control for an 8-bit successive-approximation converter with a serial read port. It runs on its own free-running conversion clock. A host drives an active-low chip-select and a serial I/O clock, and neither signal has any required phase or frequency relation to the conversion clock. While selected, the block presents the last completed result on a tri-stateable data pin, most significant bit first. It also tells the analog front end when to track the input and when to freeze it.

On the eighth falling I/O clock edge the block opens a 36-cycle window. The first four cycles let the held voltage settle. The remaining 32 cycles resolve one result bit every four cycles, starting with the most significant bit. In each slot a trial bit is placed on the DAC code output and the comparator answer is taken on the last cycle of the slot. A finished conversion replaces the result register. A conversion that is cut short by a reselect, or by a fresh eight-edge sequence, leaves the result register unchanged.

Top module: `sar_serial_seq`

## Requirements
- R1: `dout_en_o` is 0 in the same cycle that `cs_n_i` is high, and 1 while `cs_n_i` is low.
- R2: A low level on the synchronized chip-select is accepted only after it has lasted `CS_QUAL` (3) consecutive clock cycles. A shorter low pulse is ignored: it neither aborts a running conversion nor starts a transfer.
- R3: After an accepted select, `dout_o` shows bit 7 of the result register. Each of the first seven I/O clock falling edges advances `dout_o` to the next lower bit (7, 6, …, 0).
- R4: `sample_o` is 1 from the fourth falling I/O clock edge until the eighth falling edge. It is never 1 at the same time as `hold_o`, and never 1 without an accepted select.
- R5: The eighth falling edge raises `hold_o` for exactly 36 cycles: 4 settling cycles, then 8 bit slots of 4 cycles each, MSB first. In each slot the trial bit is set on `sar_o` and is kept when `cmp_i` is 1 on the slot's last cycle. Outside the window `sar_o` is 0.
- R6: The result register (reset value 0x00) changes only at the end of an uninterrupted 36-cycle window. The next read returns the converted value.
- R7: If chip-select goes high and a new low is accepted while `hold_o` is 1, the conversion stops (`hold_o` falls) and the result register keeps its earlier value.
- R8: Eight falling edges issued with chip-select held low during a window abandon that conversion and start a new one. The bits read during that sequence are the earlier completed result.
- R9: Chip-select may stay low across back-to-back conversions. The edge counter keeps running, so one spurious falling edge makes the seventh following edge start a conversion.
- R10: Reset clears `hold_o`, `sample_o`, `sar_o` and the result register.
- R11: I/O clock edges while chip-select is high are ignored: no conversion starts and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Host chip-select, active low, asynchronous |
| sclk_i | input | 1 | Host serial I/O clock, asynchronous |
| cmp_i | input | 1 | Comparator answer: 1 when the input is at or above the DAC code |
| dout_o | output | 1 | Serial result bit |
| dout_en_o | output | 1 | Drive enable for the serial data pin (0 = high impedance) |
| sample_o | output | 1 | Front end tracks the analog input |
| hold_o | output | 1 | Front end holds; conversion window active |
| sar_o | output | DATA_W | Trial code for the comparator DAC |

## Verification
Each I/O clock falling edge reaches `dout_o` three clock edges later: two synchronizer flops and the shift register. A select is accepted about six edges after `cs_n_i` falls. The bench therefore holds every I/O clock level for six cycles, samples data just before each falling edge, and waits ten cycles after a select before the first edge. `hold_o` rises three edges after the eighth falling edge and stays up for 36 cycles. The bench measures the run length at every falling clock edge and waits 50 cycles before it reads a new result. The abort and glitch cases probe `hold_o` about 20 cycles into the window, where a live conversion is still certain to be running.

// File: rtl/sss_pkg.sv
package sss_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_CONV = 2'd2
    } conv_phase_e;
endpackage

// File: rtl/sss_sync.sv
module sss_sync #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        typedef struct packed {
            logic meta;
            logic stable;
        } sync_t;

        sync_t st_d, st_q;

        always_comb begin
            st_d.meta   = async_i[i];
            st_d.stable = st_q.meta;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q.meta   <= RST_VAL[i];
                st_q.stable <= RST_VAL[i];
            end else begin
                st_q <= st_d;
            end
        end

        assign sync_o[i] = st_q.stable;
    end
endmodule

// File: rtl/sss_csqual.sv
module sss_csqual #(
    parameter int QUAL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    output logic active_o
);
    localparam int QW = $clog2(QUAL + 1);

    typedef struct packed {
        logic [QW-1:0] cnt;
        logic          act;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_n_s) begin
            st_d.cnt = '0;
            st_d.act = 1'b0;
        end else if (!st_q.act) begin
            if (st_q.cnt == QW'(QUAL - 1)) begin
                st_d.act = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.act <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.act;
endmodule

// File: rtl/sss_sar.sv
module sss_sar
    import sss_pkg::*;
#(
    parameter int W    = 8,
    parameter int HOLD = 4,
    parameter int SLOT = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         abort_i,
    input  logic         cmp_i,
    output logic         hold_o,
    output logic [W-1:0] sar_o,
    output logic [W-1:0] result_o
);
    localparam int HW = $clog2(HOLD + 1);
    localparam int SW = $clog2(SLOT + 1);
    localparam int BW = $clog2(W);

    typedef struct packed {
        conv_phase_e   ph;
        logic [HW-1:0] hcnt;
        logic [SW-1:0] scnt;
        logic [BW-1:0] bidx;
        logic [W-1:0]  sar;
        logic [W-1:0]  res;
    } sar_st_t;

    sar_st_t    st_d, st_q;
    logic [W-1:0] decided;

    always_comb begin
        st_d    = st_q;
        decided = st_q.sar;
        decided[st_q.bidx] = cmp_i;
        if (start_i) begin
            st_d.ph   = PH_HOLD;
            st_d.hcnt = '0;
            st_d.scnt = '0;
            st_d.bidx = BW'(W - 1);
            st_d.sar  = '0;
        end else if (abort_i) begin
            st_d.ph   = PH_IDLE;
            st_d.hcnt = '0;
            st_d.scnt = '0;
            st_d.sar  = '0;
        end else begin
            case (st_q.ph)
                PH_HOLD: begin
                    if (st_q.hcnt == HW'(HOLD - 1)) begin
                        st_d.ph          = PH_CONV;
                        st_d.hcnt        = '0;
                        st_d.scnt        = '0;
                        st_d.bidx        = BW'(W - 1);
                        st_d.sar         = '0;
                        st_d.sar[W-1]    = 1'b1;
                    end else begin
                        st_d.hcnt = st_q.hcnt + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (st_q.scnt == SW'(SLOT - 1)) begin
                        st_d.scnt = '0;
                        if (st_q.bidx == '0) begin
                            st_d.res = decided;
                            st_d.sar = '0;
                            st_d.ph  = PH_IDLE;
                        end else begin
                            st_d.sar = decided;
                            st_d.sar[st_q.bidx - 1'b1] = 1'b1;
                            st_d.bidx = st_q.bidx - 1'b1;
                        end
                    end else begin
                        st_d.scnt = st_q.scnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.hcnt <= '0;
            st_q.scnt <= '0;
            st_q.bidx <= '0;
            st_q.sar  <= '0;
            st_q.res  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o   = (st_q.ph != PH_IDLE);
    assign sar_o    = st_q.sar;
    assign result_o = st_q.res;
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
    parameter int DATA_W   = 8,
    parameter int CS_QUAL  = 3,
    parameter int HOLD_CYC = 4,
    parameter int SLOT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              cmp_i,
    output logic              dout_o,
    output logic              dout_en_o,
    output logic              sample_o,
    output logic              hold_o,
    output logic [DATA_W-1:0] sar_o
);
    localparam int CW        = $clog2(DATA_W);
    localparam int SAMPLE_AT = DATA_W / 2;

    typedef struct packed {
        logic              sclk_prev;
        logic              act_prev;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] shreg;
    } io_st_t;

    io_st_t            st_d, st_q;
    logic [1:0]        sync_w;
    logic              cs_n_s, sclk_s, cs_act;
    logic              fall, conv_start, conv_abort;
    logic [DATA_W-1:0] result_w;

    sss_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, cs_n_i}),
        .sync_o  (sync_w)
    );
    assign cs_n_s = sync_w[0];
    assign sclk_s = sync_w[1];

    sss_csqual #(.QUAL(CS_QUAL)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .active_o (cs_act)
    );

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        st_d.act_prev  = cs_act;
        fall           = cs_act & st_q.sclk_prev & ~sclk_s;
        conv_start     = 1'b0;
        conv_abort     = cs_act & ~st_q.act_prev & hold_o;
        if (!cs_act) begin
            st_d.cnt   = '0;
            st_d.shreg = result_w;
        end else if (fall) begin
            st_d.shreg = {st_q.shreg[DATA_W-2:0], 1'b0};
            if (st_q.cnt == CW'(DATA_W - 1)) begin
                st_d.cnt   = '0;
                conv_start = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (st_q.cnt == '0) begin
            st_d.shreg = result_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk_prev <= 1'b0;
            st_q.act_prev  <= 1'b0;
            st_q.cnt       <= '0;
            st_q.shreg     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sss_sar #(.W(DATA_W), .HOLD(HOLD_CYC), .SLOT(SLOT_CYC)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (conv_start),
        .abort_i  (conv_abort),
        .cmp_i    (cmp_i),
        .hold_o   (hold_o),
        .sar_o    (sar_o),
        .result_o (result_w)
    );

    assign dout_o    = st_q.shreg[DATA_W-1];
    assign dout_en_o = ~cs_n_i;
    assign sample_o  = cs_act & (st_q.cnt >= CW'(SAMPLE_AT)) & ~hold_o;
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 4,
    parameter int SLOT_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              start,
    input logic              sample,
    input logic              hold,
    input logic [DATA_W-1:0] sar,
    input logic [DATA_W-1:0] result
);
    localparam int WIN = HOLD_CYC + DATA_W * SLOT_CYC;
    localparam int RW  = $clog2(WIN + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (start)  run_q <= '0;
        else if (hold)   run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    a_r5_window_max: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(WIN));

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && hold));

    a_r4_sample_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> cs_act);

    a_r6_result_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> ($past(hold) && !hold));

    a_r5_sar_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |-> (sar == '0));
endmodule

bind sar_serial_seq sss_checker #(
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD_CYC),
    .SLOT_CYC (SLOT_CYC)
) u_sss_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_act (cs_act),
    .start  (conv_start),
    .sample (sample_o),
    .hold   (hold_o),
    .sar    (sar_o),
    .result (result_w)
);

// File: tb/test_sar_serial_seq.sv
module test_sar_serial_seq;
    localparam int NV = 6;
    localparam logic [15:0] VEC [NV] = '{
        {8'hA5, 8'h00}, {8'h00, 8'hA5}, {8'hFF, 8'h00},
        {8'h5A, 8'hFF}, {8'h80, 8'h5A}, {8'h01, 8'h80}
    };

    logic       clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0;
    logic [7:0] vin = 8'h00;
    logic       dout, dout_en, sample, hold, cmp;
    logic [7:0] sar;
    int         checks = 0, errors = 0;
    int         hold_len = 0, last_run = 0, hold_rises = 0;

    assign cmp = (vin >= sar);

    always #2 clk = ~clk;

    sar_serial_seq i_sar_serial_seq (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .cmp_i(cmp),
        .dout_o(dout), .dout_en_o(dout_en), .sample_o(sample),
        .hold_o(hold), .sar_o(sar)
    );

    always @(negedge clk) begin
        if (hold) begin
            if (hold_len == 0) hold_rises++;
            hold_len++;
        end else if (hold_len != 0) begin
            last_run = hold_len;
            hold_len = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input int half, input bit chk, output logic [7:0] rd);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b1; wait_n(half);
            rd[7-i] = dout;
            sclk = 1'b0; wait_n(half);
            if (chk) check("R4 sample", 32'(sample), 32'(i >= 3 && i < 7));
        end
        if (chk) check("R5 hold up", 32'(hold), 32'd1);
    endtask

    task automatic select_dev();
        cs_n = 1'b0; wait_n(10);
    endtask

    task automatic deselect_dev();
        cs_n = 1'b1; wait_n(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int rises0;
        wait_n(3);
        check("R10 hold", 32'(hold), 0);
        check("R10 sample", 32'(sample), 0);
        check("R10 sar", 32'(sar), 0);
        check("R1 deselected", 32'(dout_en), 0);
        rst_n = 1'b1; wait_n(3);

        // Vector table: {input level, value expected from this read}
        for (int k = 0; k < NV; k++) begin
            vin = VEC[k][15:8];
            select_dev();
            xfer(6, k == 0, rd);
            check("R3 R6 read", 32'(rd), 32'(VEC[k][7:0]));
            deselect_dev();
            wait_n(50);
            check("R5 window length", last_run, 36);
        end

        // R1: enable follows chip-select at once
        vin = 8'h3C;
        cs_n = 1'b0; #1;
        check("R1 selected", 32'(dout_en), 1);
        wait_n(10);
        xfer(6, 1'b0, rd);
        check("R3 read", 32'(rd), 32'h01);
        cs_n = 1'b1; #1;
        check("R1 released", 32'(dout_en), 0);
        wait_n(50);

        // R11: clocks while deselected are ignored
        rises0 = hold_rises;
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b1; wait_n(6); sclk = 1'b0; wait_n(6);
        end
        wait_n(20);
        check("R11 no window", hold_rises, rises0);
        vin = 8'hC3;
        select_dev(); xfer(6, 1'b0, rd);
        check("R11 result kept", 32'(rd), 32'h3C);
        deselect_dev(); wait_n(50);

        // R7: reselect during the window aborts it
        vin = 8'h77;
        select_dev(); xfer(6, 1'b0, rd);
        check("R7 read", 32'(rd), 32'hC3);
        cs_n = 1'b1; wait_n(4); cs_n = 1'b0; wait_n(10);
        check("R7 hold dropped", 32'(hold), 0);
        wait_n(50);
        vin = 8'h11;
        xfer(6, 1'b0, rd);
        check("R7 result kept", 32'(rd), 32'hC3);
        deselect_dev(); wait_n(50);

        // R2: a short select glitch is ignored
        vin = 8'h6E;
        select_dev(); xfer(6, 1'b0, rd);
        check("R2 read", 32'(rd), 32'h11);
        cs_n = 1'b1; wait_n(4); cs_n = 1'b0; wait_n(1); cs_n = 1'b1;
        wait_n(10);
        check("R2 not aborted", 32'(hold), 1);
        wait_n(50);
        select_dev(); xfer(6, 1'b0, rd);
        check("R2 result", 32'(rd), 32'h6E);
        deselect_dev(); wait_n(50);

        // R8: new sequence during the window restarts conversion
        vin = 8'h99;
        select_dev(); xfer(2, 1'b0, rd);
        check("R8 first read", 32'(rd), 32'h6E);
        vin = 8'h42;
        xfer(2, 1'b0, rd);
        check("R8 old result", 32'(rd), 32'h6E);
        wait_n(50);
        xfer(6, 1'b0, rd);
        check("R8 new result", 32'(rd), 32'h42);
        deselect_dev(); wait_n(50);

        // R9: spurious edge with select held low shifts the count
        select_dev();
        sclk = 1'b1; wait_n(6); sclk = 1'b0; wait_n(6);
        for (int i = 0; i < 7; i++) begin
            sclk = 1'b1; wait_n(6); sclk = 1'b0; wait_n(6);
        end
        wait_n(4);
        check("R9 early start", 32'(hold), 1);
        wait_n(50);
        vin = 8'h24;
        xfer(6, 1'b0, rd);
        check("R9 back to back", 32'(rd), 32'h42);
        wait_n(50);
        xfer(6, 1'b0, rd);
        check("R9 second", 32'(rd), 32'h24);
        deselect_dev(); wait_n(10);

        // R10: reset clears the result
        rst_n = 1'b0; wait_n(3);
        check("R10 hold again", 32'(hold), 0);
        rst_n = 1'b1; wait_n(3);
        select_dev(); xfer(6, 1'b0, rd);
        check("R10 result cleared", 32'(rd), 32'h00);
        deselect_dev(); wait_n(50);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule